// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between on-chip logic and an external 8,192 x 8 asynchronous static RAM. Internal logic issues single-byte read or write requests over a request/ready handshake. The controller turns each request into a pin sequence that meets the memory's nanosecond minimums. It drives a dual-polarity chip select (one low-active line, one high-active line), a low-active write strobe, a low-active output enable, a 13-bit address and an 8-bit data bus. The data bus is split into an output value, an output-enable for the pad driver, and an input value.

Every timing minimum is a parameter in nanoseconds. The clock period is also a parameter. Each minimum becomes a whole number of clock cycles: the ceiling of the minimum divided by the period, never less than one. A write first keeps output enable high long enough for the memory's outputs to float. Only then does it lower the write strobe and switch on its own data driver. It raises the write strobe one or more cycles before it releases the data, the address and the select. A read keeps the driver off, lowers output enable, and samples the bus in the last cycle of the access window. It then returns the byte together with a one-cycle valid pulse.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is high, and whenever the block is idle, `sramCeN`=1, `sramCe`=0, `sramWeN`=1, `sramOeN`=1, `sramDqOe`=0 and `ready`=1. After reset `rdValid`=0.
- R2: A request is taken only on a clock edge where `reqValid` and `ready` are both 1. While busy, `ready`=0, and changes on the request inputs leave `sramAddr` unchanged for the rest of the access.
- R3: The memory is selected only when `sramCeN`=0 and `sramCe`=1. The two select lines never show a mixed pair.
- R4: The data driver (`sramDqOe`=1) is on only while `sramOeN`=1, and only after `sramOeN` has been high for the output-float count (40 ns default). The memory therefore never drives while the controller drives.
- R5: The write strobe stays low for max(write pulse, data setup, address-to-end minus float count) cycles: 8 cycles at 20 ns. The driven data is stable for at least the data-setup count (5 cycles) before the strobe rises.
- R6: When `sramWeN` rises, the driver, the address and the select are all still held. A selected write lasts at least the write-cycle count of 10 cycles.
- R7: A read holds `sramOeN`=0 for max(read cycle, address access, output-enable access) cycles (10 at 20 ns). It samples `sramDqIn` at the last of them. On the next cycle it shows the byte on `rdData` with `rdValid`=1 for exactly one cycle.
- R8: `sramWeN` and `sramOeN` are never low together.
- R9: With the default parameters, `ready` is low for 11 cycles after a write is taken (2 float + 8 pulse + 1 recovery) and for 10 cycles after a read is taken.
- R10: A synchronous reset in the middle of an access returns every pin to the R1 levels on the next edge, and no `rdValid` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Byte address |
| reqWdata | input | 8 | Write byte |
| ready | output | 1 | Idle and able to take a request |
| rdData | output | 8 | Last byte read |
| rdValid | output | 1 | One-cycle pulse when rdData is new |
| sramCeN | output | 1 | Low-active chip select |
| sramCe | output | 1 | High-active chip select |
| sramWeN | output | 1 | Low-active write strobe |
| sramOeN | output | 1 | Low-active output enable |
| sramAddr | output | 13 | Memory address |
| sramDqOut | output | 8 | Byte the pad drives |
| sramDqOe | output | 1 | Pad driver enable |
| sramDqIn | input | 8 | Byte seen on the pad |

## Verification
The read-data valid pulse falls in the same cycle that `ready` returns. The bench always issues its next request in that cycle, so a completing read overlaps with the acceptance of a read or a write. A read followed at once by a write is the tightest bus turnaround. A bench memory model tracks how long the memory's outputs may keep driving after output enable rises or the select drops, and it flags any cycle where the pad driver is also on. The model returns a corrupted byte if the access window is too short, and it stores a corrupted byte if the write strobe or the data setup is too short. Read-back compares therefore catch timing faults as well as data faults.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic sel;      // memory selected
    logic weN;      // write strobe level
    logic oeN;      // output enable level
    logic drvEn;    // pad driver on
    logic load;     // capture request fields
    logic capture;  // sample read bus
  } sramCtl_t;

  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int TURN_CYC  = 2,
  parameter int PULSE_CYC = 8,
  parameter int REC_CYC   = 1,
  parameter int ACC_CYC   = 10,
  parameter int CNT_W     = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     ready,
  output sramCtl_t ctl
);

  typedef enum logic [2:0] {ST_IDLE, ST_TURN, ST_PULSE, ST_REC, ST_ACC} state_t;

  state_t           state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             accept;
  logic             selQ, weNQ, oeNQ, drvQ;
  logic             selD, weND, oeND, drvD;

  assign ready  = (state == ST_IDLE);
  assign accept = reqValid && ready;

  always_comb begin
    nextState = state;
    nextCnt   = (cnt != '0) ? cnt - CNT_W'(1) : '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (reqWrite) begin
          nextState = ST_TURN;
          nextCnt   = CNT_W'(TURN_CYC - 1);
        end else begin
          nextState = ST_ACC;
          nextCnt   = CNT_W'(ACC_CYC - 1);
        end
      end
      ST_TURN: if (cnt == '0) begin
        nextState = ST_PULSE;
        nextCnt   = CNT_W'(PULSE_CYC - 1);
      end
      ST_PULSE: if (cnt == '0) begin
        nextState = ST_REC;
        nextCnt   = CNT_W'(REC_CYC - 1);
      end
      ST_REC:  if (cnt == '0) nextState = ST_IDLE;
      ST_ACC:  if (cnt == '0) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  // Pin levels decoded from the next state, then registered
  always_comb begin
    selD = 1'b1; weND = 1'b1; oeND = 1'b1; drvD = 1'b0;
    unique case (nextState)
      ST_IDLE:  selD = 1'b0;
      ST_TURN:  ;
      ST_PULSE: begin weND = 1'b0; drvD = 1'b1; end
      ST_REC:   drvD = 1'b1;
      ST_ACC:   oeND = 1'b0;
      default:  selD = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      selQ  <= 1'b0;
      weNQ  <= 1'b1;
      oeNQ  <= 1'b1;
      drvQ  <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      selQ  <= selD;
      weNQ  <= weND;
      oeNQ  <= oeND;
      drvQ  <= drvD;
    end
  end

  assign ctl = '{sel: selQ, weN: weNQ, oeN: oeNQ, drvEn: drvQ,
                 load: accept,
                 capture: (state == ST_ACC) && (cnt == '0)};

  // R1: idle implies quiet pins
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!ctl.sel && ctl.weN && ctl.oeN && !ctl.drvEn));

  // R7: sampling only inside an enabled read
  p_capture_read_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |-> (ctl.sel && !ctl.oeN && !ctl.drvEn));

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sramCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic              sramCeN,
  output logic              sramCe,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int RUN_W = $clog2(TURN_CYC + 2);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [RUN_W-1:0]  oeHighRun;

  always_ff @(posedge clk) begin
    if (ctl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= sramDqIn;
    end
  end

  assign sramCeN   = ~ctl.sel;
  assign sramCe    = ctl.sel;
  assign sramWeN   = ctl.weN;
  assign sramOeN   = ctl.oeN;
  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = ctl.drvEn;

  // Checker counter: cycles output enable has stayed high
  always_ff @(posedge clk) begin
    if (rst) oeHighRun <= '0;
    else if (!sramOeN) oeHighRun <= '0;
    else if (oeHighRun < RUN_W'(TURN_CYC)) oeHighRun <= oeHighRun + RUN_W'(1);
  end

  // R4: driver only after the float window
  p_drive_after_float_r4: assert property (@(posedge clk) disable iff (rst)
    sramDqOe |-> (sramOeN && oeHighRun >= RUN_W'(TURN_CYC)));

  // R8: never strobe write with outputs enabled
  p_we_oe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(!sramWeN && !sramOeN));

  // R6: strobe released while data, select held
  p_we_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sramWeN) |-> (sramDqOe && !sramCeN && sramCe));

  // R7: single-cycle valid
  p_rdvalid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  // R2: address steady through a selected access
  p_addr_steady_r2: assert property (@(posedge clk) disable iff (rst)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 200,
  parameter int T_AA_NS       = 200,
  parameter int T_OE_NS       = 150,
  parameter int T_WP_NS       = 150,
  parameter int T_DW_NS       = 100,
  parameter int T_AW_NS       = 180,
  parameter int T_WC_NS       = 200,
  parameter int T_OHZ_NS      = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              sramCeN,
  output logic              sramCe,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int TURN_CYC  = cyclesFor(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = maxOf(maxOf(cyclesFor(T_WP_NS, CLK_PERIOD_NS),
                                         cyclesFor(T_DW_NS, CLK_PERIOD_NS)),
                                   maxOf(1, cyclesFor(T_AW_NS, CLK_PERIOD_NS) - TURN_CYC));
  localparam int REC_CYC   = maxOf(1, cyclesFor(T_WC_NS, CLK_PERIOD_NS) - TURN_CYC - PULSE_CYC);
  localparam int ACC_CYC   = maxOf(cyclesFor(T_RC_NS, CLK_PERIOD_NS),
                                   maxOf(cyclesFor(T_AA_NS, CLK_PERIOD_NS),
                                         cyclesFor(T_OE_NS, CLK_PERIOD_NS)));
  localparam int MAX_CYC   = maxOf(maxOf(TURN_CYC, PULSE_CYC), maxOf(REC_CYC, ACC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  sramCtl_t ctl;

  sram_ctl_fsm #(
    .TURN_CYC(TURN_CYC), .PULSE_CYC(PULSE_CYC), .REC_CYC(REC_CYC),
    .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
  ) uCtl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .ready(ready), .ctl(ctl)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_CYC(TURN_CYC)
  ) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .sramDqIn(sramDqIn), .sramCeN(sramCeN), .sramCe(sramCe),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/1ps
module sim_sram_port_ctrl;

  localparam int PER = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TURN   = cyc(40);
  localparam int WP_MIN = cyc(150);
  localparam int DW_MIN = cyc(100);
  localparam int PULSE  = mx(mx(WP_MIN, DW_MIN), mx(1, cyc(180) - TURN));
  localparam int REC    = mx(1, cyc(200) - TURN - PULSE);
  localparam int WC_MIN = cyc(200);
  localparam int AA_MIN = cyc(200);
  localparam int OE_MIN = cyc(150);
  localparam int WR_LAT = TURN + PULSE + REC;
  localparam int RD_LAT = mx(cyc(200), mx(AA_MIN, OE_MIN));
  localparam int TAIL   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ready, rdValid;
  logic [7:0]  rdData;
  logic        sramCeN, sramCe, sramWeN, sramOeN, sramDqOe;
  logic [12:0] sramAddr;
  logic [7:0]  sramDqOut;
  logic [7:0]  sramDqIn = 8'hA5;

  int checks = 0, errors = 0;
  bit done = 0;
  bit skipSel = 0;

  always #(PER/2) clk = ~clk;

  sram_port_ctrl u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .rdData(rdData),
    .rdValid(rdValid), .sramCeN(sramCeN), .sramCe(sramCe), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramAddr(sramAddr), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] initByte(input logic [12:0] a);
    return 8'(a * 37 + 11);
  endfunction

  logic [7:0] modelMem[int];
  logic [7:0] expMem[int];

  function automatic logic [7:0] modelRd(input logic [12:0] a);
    return modelMem.exists(int'(a)) ? modelMem[int'(a)] : initByte(a);
  endfunction
  function automatic logic [7:0] expRd(input logic [12:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : initByte(a);
  endfunction

  // Memory model, evaluated once per cycle
  int addrRun = 0, oeRun = 0, weRun = 0, dStable = 0, selRun = 0, sinceActive = 99;
  int lastWeRun = 0, lastDStable = 0;
  logic [12:0] prevAddr = '0, wAddr = '0;
  logic [7:0]  prevDq = '0, wData = '0;
  bit prevSel = 0, prevWriting = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      automatic bit sel = !sramCeN && sramCe;
      automatic bit writing = sel && !sramWeN;
      automatic bit active;
      automatic bit driving;
      check(sramCeN != sramCe, "R3 select pair", {sramCeN, sramCe}, 2'b10);
      check(!(!sramWeN && !sramOeN), "R8 strobe overlap", {sramWeN, sramOeN}, 2'b11);
      if (prevWriting && !writing) begin
        check(sel && sramDqOe, "R6 held at strobe rise", {sel, sramDqOe}, 2'b11);
        check(lastWeRun >= WP_MIN, "R5 pulse width", lastWeRun, WP_MIN);
        check(lastDStable >= DW_MIN, "R5 data setup", lastDStable, DW_MIN);
        modelMem[int'(wAddr)] = (lastWeRun >= WP_MIN && lastDStable >= DW_MIN) ? wData : ~wData;
      end
      if (prevSel && !sel) begin
        if (skipSel) skipSel = 0;
        else check(selRun >= WC_MIN, "R6 select length", selRun, WC_MIN);
      end
      addrRun = sel ? ((sramAddr == prevAddr && addrRun > 0) ? addrRun + 1 : 1) : 0;
      oeRun   = (sel && !sramOeN) ? oeRun + 1 : 0;
      weRun   = writing ? weRun + 1 : 0;
      dStable = sramDqOe ? ((dStable > 0 && sramDqOut == prevDq) ? dStable + 1 : 1) : 0;
      selRun  = sel ? selRun + 1 : 0;
      if (writing) begin
        wAddr = sramAddr; wData = sramDqOut;
        lastWeRun = weRun; lastDStable = dStable;
      end
      active = sel && sramWeN && !sramOeN;
      sinceActive = active ? 0 : ((sinceActive < 99) ? sinceActive + 1 : 99);
      driving = active || (sinceActive >= 1 && sinceActive <= TAIL);
      if (sramDqOe) check(!driving, "R4 bus contention", sinceActive, TAIL + 1);
      if (active)
        sramDqIn = (oeRun >= OE_MIN && addrRun >= AA_MIN) ? modelRd(sramAddr)
                                                         : ~modelRd(sramAddr);
      prevAddr = sramAddr; prevDq = sramDqOut;
      prevSel = sel; prevWriting = writing;
    end
  end

  task automatic checkIdle(input string tag);
    check(sramCeN && !sramCe && sramWeN && sramOeN && !sramDqOe && ready, tag,
          {sramCeN, sramCe, sramWeN, sramOeN, sramDqOe, ready}, 6'b101101);
  endtask

  // Issue at a negedge with ready high; returns at the negedge ready is back
  task automatic runOp(input bit wr, input logic [12:0] a, input logic [7:0] d);
    automatic int busy = 0;
    automatic logic [7:0] want = expRd(a);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    while (!ready && busy < 100) begin
      if (busy == 0) check(rdValid == 1'b0, "R7 valid one cycle", rdValid, 0);
      check(sramAddr == a, "R2 address held while busy", sramAddr, a);
      reqAddr = 13'($urandom); reqWdata = 8'($urandom); reqWrite = 1'($urandom);
      busy++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(busy == (wr ? WR_LAT : RD_LAT), wr ? "R9 write latency" : "R9 read latency",
          busy, wr ? WR_LAT : RD_LAT);
    if (wr) begin
      check(rdValid == 1'b0, "R7 no valid after write", rdValid, 0);
      expMem[int'(a)] = d;
    end else begin
      check(rdValid == 1'b1, "R7 valid after read", rdValid, 1);
      check(rdData == want, "R7 read data", rdData, want);
    end
    checkIdle("R1 idle after access");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checkIdle("R1 pins in reset");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1 pins after reset");
    check(rdValid == 1'b0, "R1 valid after reset", rdValid, 0);

    // Directed corners
    runOp(1'b1, 13'h0000, 8'h3C);
    runOp(1'b0, 13'h0000, 8'h00);
    runOp(1'b1, 13'h1FFF, 8'hFF);   // read then write back to back: turnaround
    runOp(1'b0, 13'h1FFF, 8'h00);
    runOp(1'b0, 13'h0800, 8'h00);   // never written
    runOp(1'b1, 13'h0800, 8'h00);
    runOp(1'b0, 13'h0800, 8'h00);

    // R10: reset during a read
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 13'h0000;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    skipSel = 1; rst = 1'b1;
    @(negedge clk);
    checkIdle("R10 pins after mid reset");
    rst = 1'b0;
    repeat (RD_LAT + 2) begin
      @(negedge clk);
      check(rdValid == 1'b0, "R10 no valid after abort", rdValid, 0);
    end
    checkIdle("R10 idle after abort");

    // Random mix over a small window
    for (int i = 0; i < 300; i++) begin
      automatic bit wr = 1'($urandom);
      automatic logic [12:0] a = 13'($urandom_range(0, 15));
      if (i % 50 == 0) a = 13'h1FF0 + 13'($urandom_range(0, 15));
      runOp(wr, a, 8'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule